// File: doc/BRIEF.md
# Double-Buffered Compare Timer

A 16-bit up-counting timer with two compare channels. Each channel has a software-writable preset register that acts as a shadow of its active compare register. The counter runs while the `run` input is high and clears to zero on the cycle after it equals compare register 1. Compare register 1 therefore sets the period, and compare register 2 marks a point inside it. The block signals a match pulse per channel and raises a one-cycle interrupt pulse each time the counter clears.

Presets arrive either over a byte-wide register bus or through a 16-bit write strobe. On the byte bus a low-byte write only stages the value. The high-byte write commits both halves to the preset together, so a half-written value is never moved into a compare register. The run state decides where a committed value goes. While stopped, the value also reaches the compare register at once. While running, the value waits in the preset until the next counter clear, when both compare registers reload together. A write that coincides with that clear is resolved in favour of the new data. Preset and staging registers have no reset value, so software must write both channels while stopped before it starts counting.

Top module: `dbuf_cmp_timer`

## Requirements
- R1: After reset, `count` is 0, `clr_irq` is 0, and with `run` low both match outputs are 0. The compare registers reset to 0.
- R2: A committed preset write made while `run` is low is copied into the compare register at the same clock edge. The new value governs matching as soon as counting starts.
- R3: A committed preset write made while `run` is high leaves the compare register unchanged until the next counter clear. At that clear both compare registers load their presets, and matching uses the new values from count 0 onward.
- R4: While running, `match1` is high in the cycle where `count` equals compare register 1, and `count` is 0 in the next cycle. `clr_irq` is high for exactly that following cycle.
- R5: While running, `match2` is high in each cycle where `count` equals compare register 2.
- R6: On the byte bus, address 0 stages the low byte of channel 1 and address 2 stages the low byte of channel 2; neither changes a preset. Address 1 or address 3 writes the high byte and commits {high, staged low} to the preset of channel 1 or channel 2.
- R7: `wide_we` writes `wide_wdata` as one 16-bit value to channel 1 (`wide_ch` = 0) or channel 2 (`wide_ch` = 1). In a cycle with `wide_we` high, any byte-bus write is ignored.
- R8: If a preset commit lands in the same cycle as a counter clear while running, the compare register receives the newly written value, not the older preset.
- R9: While `run` is low, `count` holds its value and `match1`, `match2` and `clr_irq` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Counting enable (1 = run, 0 = stop) |
| reg_we | input | 1 | Byte-bus write strobe |
| reg_addr | input | 2 | Byte-bus address: 0/1 = ch1 low/high, 2/3 = ch2 low/high |
| reg_wdata | input | W/2 | Byte-bus write data |
| wide_we | input | 1 | 16-bit preset write strobe |
| wide_ch | input | 1 | Channel of the 16-bit write (0 = ch1, 1 = ch2) |
| wide_wdata | input | W | 16-bit preset write data |
| count | output | W | Current counter value |
| match1 | output | 1 | Counter equals compare register 1 while running |
| match2 | output | 1 | Counter equals compare register 2 while running |
| clr_irq | output | 1 | One-cycle pulse in the cycle after a counter clear |

## Verification
The hardest case to reach from the ports is a preset commit that falls on the exact cycle in which the counter clears. The bench waits at the falling edge until `count` shows the current period value and asserts the 16-bit write for that single cycle. It then confirms that the next period ends at the new value and not at the older preset. A second delicate case is a pending preset held across a clear without being committed. This case is reached by writing only a low byte mid-period and letting a full period pass before the high byte arrives.

// File: rtl/dbuf_cmp_timer.sv
module dbuf_cmp_timer #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic           reg_we,
  input  logic [1:0]     reg_addr,
  input  logic [W/2-1:0] reg_wdata,
  input  logic           wide_we,
  input  logic           wide_ch,
  input  logic [W-1:0]   wide_wdata,
  output logic [W-1:0]   count,
  output logic           match1,
  output logic           match2,
  output logic           clr_irq
);
  localparam int B = W / 2;

  logic [B-1:0] lo1_q, lo2_q;
  logic [W-1:0] pre1_q, pre2_q, cmp1_q, cmp2_q, cnt_q;
  logic [W-1:0] data1, data2;
  logic         commit1, commit2, byte_ok, hit1, irq_q;

  assign byte_ok = reg_we && !wide_we;
  assign commit1 = wide_we ? !wide_ch : (reg_we && reg_addr == 2'd1);
  assign commit2 = wide_we ?  wide_ch : (reg_we && reg_addr == 2'd3);
  assign data1   = wide_we ? wide_wdata : {reg_wdata, lo1_q};
  assign data2   = wide_we ? wide_wdata : {reg_wdata, lo2_q};

  assign hit1    = run && (cnt_q == cmp1_q);
  assign match1  = hit1;
  assign match2  = run && (cnt_q == cmp2_q);
  assign count   = cnt_q;
  assign clr_irq = irq_q;

  always_ff @(posedge clk) begin
    if (byte_ok && reg_addr == 2'd0) lo1_q <= reg_wdata;
    if (byte_ok && reg_addr == 2'd2) lo2_q <= reg_wdata;
    if (commit1) pre1_q <= data1;
    if (commit2) pre2_q <= data2;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp1_q <= '0;
      cmp2_q <= '0;
    end else if (!run) begin
      if (commit1) cmp1_q <= data1;
      if (commit2) cmp2_q <= data2;
    end else if (hit1) begin
      cmp1_q <= commit1 ? data1 : pre1_q;
      cmp2_q <= commit2 ? data2 : pre2_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= hit1;
      if (run) cnt_q <= hit1 ? '0 : cnt_q + 1'b1;
    end
  end

  assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit1 |=> (cnt_q == '0) && irq_q);
  assert_irq_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (cnt_q == '0));
  assert_stop_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == $past(cnt_q)) && !irq_q);
  assert_stopped_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && commit1) |=> (cmp1_q == $past(data1)));
  assert_run_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !hit1) |=> (cmp1_q == $past(cmp1_q)) && (cmp2_q == $past(cmp2_q)));
  assert_collide_new_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit1 && commit2) |=> (cmp2_q == $past(data2)));
  assert_stage_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_ok && reg_addr == 2'd0) |=> (pre1_q == $past(pre1_q)));
endmodule

// File: tb/tb_dbuf_cmp_timer.sv
module tb_dbuf_cmp_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic        wide_we = 1'b0;
  logic        wide_ch = 1'b0;
  logic [15:0] wide_wdata = '0;
  logic [15:0] count;
  logic        match1, match2, clr_irq;

  int tests = 0;
  int fails = 0;
  string phase = "R1";
  bit done = 1'b0;

  always #5 clk = ~clk;

  dbuf_cmp_timer #(.W(16)) dut (
    .clk(clk), .rst_n(rst_n), .run(run), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .wide_we(wide_we), .wide_ch(wide_ch),
    .wide_wdata(wide_wdata), .count(count), .match1(match1), .match2(match2),
    .clr_irq(clr_irq)
  );

  // behavioural reference
  int m_cnt = 0, m_cmp1 = 0, m_cmp2 = 0, m_pre1 = 0, m_pre2 = 0;
  int m_lo1 = 0, m_lo2 = 0;
  bit m_irq = 0;

  always @(posedge clk) begin
    int v1, v2;
    bit c1, c2, wrap;
    if (!rst_n) begin
      m_cnt = 0; m_cmp1 = 0; m_cmp2 = 0; m_irq = 0;
    end else begin
      c1 = 0; c2 = 0; v1 = 0; v2 = 0;
      if (wide_we) begin
        if (wide_ch) begin c2 = 1; v2 = wide_wdata; end
        else begin c1 = 1; v1 = wide_wdata; end
      end else if (reg_we) begin
        case (reg_addr)
          2'd0: m_lo1 = reg_wdata;
          2'd1: begin c1 = 1; v1 = reg_wdata * 256 + m_lo1; end
          2'd2: m_lo2 = reg_wdata;
          default: begin c2 = 1; v2 = reg_wdata * 256 + m_lo2; end
        endcase
      end
      wrap = run && (m_cnt == m_cmp1);
      if (c1) m_pre1 = v1;
      if (c2) m_pre2 = v2;
      if (!run) begin
        if (c1) m_cmp1 = v1;
        if (c2) m_cmp2 = v2;
      end else if (wrap) begin
        m_cmp1 = m_pre1;
        m_cmp2 = m_pre2;
      end
      m_irq = wrap;
      if (run) m_cnt = wrap ? 0 : (m_cnt + 1) % 65536;
    end
  end

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always begin
    @(posedge clk);
    #2;
    if (rst_n && !done) begin
      check({phase, " count"}, count, m_cnt);
      check({phase, " match1"}, match1, run && (m_cnt == m_cmp1));
      check({phase, " match2"}, match2, run && (m_cnt == m_cmp2));
      check({phase, " clr_irq"}, clr_irq, m_irq);
    end
  end

  task automatic wait_cnt(int v);
    for (int i = 0; i < 200; i++) begin
      if (count == v) return;
      @(negedge clk);
    end
    check("watchdog wait_cnt", count, v);
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 200; i++) begin
      if (clr_irq) return;
      @(negedge clk);
    end
    check("watchdog wait_irq", 0, 1);
  endtask

  task automatic wide_wr(bit ch, int v);
    wide_we = 1; wide_ch = ch; wide_wdata = v[15:0];
    @(negedge clk);
    wide_we = 0;
  endtask

  task automatic byte_wr(int a, int v);
    reg_we = 1; reg_addr = a[1:0]; reg_wdata = v[7:0];
    @(negedge clk);
    reg_we = 0;
  endtask

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    phase = "R1";
    check("R1 count", count, 0);
    check("R1 irq", clr_irq, 0);
    check("R1 match1", match1, 0);

    phase = "R7";
    wide_wr(0, 9);
    wide_wr(1, 4);
    repeat (2) @(negedge clk);
    check("R9 stopped match1", match1, 0);
    check("R9 stopped count", count, 0);

    phase = "R2";
    run = 1;
    wait_cnt(4);
    check("R5 match2 at 4", match2, 1);
    wait_cnt(9);
    check("R2 match1 at 9", match1, 1);
    @(negedge clk);
    check("R4 wrap count", count, 0);
    check("R4 irq", clr_irq, 1);
    @(negedge clk);
    check("R4 irq one cycle", clr_irq, 0);

    phase = "R6";
    wait_cnt(2);
    byte_wr(0, 5);
    wait_irq();
    wait_cnt(9);
    check("R6 low byte alone keeps period", match1, 1);
    wait_cnt(2);
    byte_wr(1, 0);
    phase = "R3";
    wait_cnt(5);
    check("R3 pending preset not active", match1, 0);
    wait_cnt(9);
    check("R3 old period until clear", match1, 1);
    wait_irq();
    wait_cnt(5);
    check("R3 new period after clear", match1, 1);

    phase = "R8";
    wait_irq();
    wait_cnt(5);
    wide_wr(0, 7);
    check("R8 wrap on collision", count, 0);
    wait_cnt(5);
    check("R8 old preset not used", match1, 0);
    wait_cnt(7);
    check("R8 new data loaded", match1, 1);

    phase = "R9";
    wait_cnt(3);
    run = 0;
    repeat (4) @(negedge clk);
    check("R9 count held", count, 3);
    check("R9 no match2", match2, 0);
    check("R9 no irq", clr_irq, 0);
    byte_wr(2, 6);
    byte_wr(3, 0);
    phase = "R2";
    run = 1;
    wait_cnt(6);
    check("R2 stopped byte commit active", match2, 1);
    wait_cnt(7);
    check("R4 match1 at 7", match1, 1);

    phase = "R7";
    wait_cnt(2);
    wide_we = 1; wide_ch = 1; wide_wdata = 16'd3;
    reg_we = 1; reg_addr = 2'd3; reg_wdata = 8'd1;
    @(negedge clk);
    wide_we = 0; reg_we = 0;
    wait_irq();
    wait_cnt(3);
    check("R7 wide wins over byte", match2, 1);
    repeat (20) @(negedge clk);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule